// File: doc/BRIEF.md
# Scanline Palette Pixel Output Engine

This block is the last stage of a tile-based video renderer. It runs from the pixel clock, counts out the raster of a 640x480 display, and produces active-low horizontal and vertical sync, a display-enable flag and a vertical-blank flag. The other renderer stages use these flags to schedule their work. During each visible line it steps through a line store of 320 palette indices. It turns each index into a color through a palette RAM and holds every color for two pixel clocks, so a 320-wide line fills a 640-wide screen.

There are two line stores. One is on screen while the renderer fills the other. The roles swap at the end of the horizontal blank that follows each visible line. A one-cycle pulse and a buffer-select output tell the renderer which store it may now write. The renderer's line-store write port always lands in the store that is not on screen, and a separate port loads palette entries. The index fetch and the palette lookup form a two-stage pipeline. Sync, enable and blank travel through matching delay stages, so all outputs describe the same raster position.

Top module: `scan_pixel_out`

## Requirements
- R1: While reset is low, de=0, hsync_n=1, vsync_n=1, vblank=0, color=0, swap_pulse=0 and free_buf=1.
- R2: A line is H_ACTIVE+H_FRONT+H_SYNC+H_BACK pixels long. de is high only for the first H_ACTIVE positions of a visible line. hsync_n is low for the H_SYNC positions that start after H_ACTIVE+H_FRONT.
- R3: A frame is V_ACTIVE+V_FRONT+V_SYNC+V_BACK lines long. vblank is high on every line from V_ACTIVE onward. vsync_n is low for the V_SYNC lines that start after V_ACTIVE+V_FRONT.
- R4: Output positions 2i and 2i+1 of a visible line show the same color, taken from line-store entry i.
- R5: The color at a visible position equals palette[line-store entry]. All outputs appear two clocks after the raster counter passes that position, and are counted from the first clock after reset is released (raster position 0).
- R6: color is zero whenever de is low.
- R7: After reset, visible line 0 of the first frame shows store 0. Every later visible line shows the other store than the line before it.
- R8: The store swap happens at the last position of a visible line's horizontal blank, and never on a blank line. swap_pulse is high for one clock at the swap. free_buf (0 = store 0, 1 = store 1) then names the store that is now writable, and it changes at no other time.
- R9: A line-store write (row_we) goes to the store named by free_buf and does not change the store on screen.
- R10: After reset, entry i of store 0 holds i and entry i of store 1 holds the bitwise inverse of i, both truncated to IDX_W bits.
- R11: A palette write (pal_we) changes the color shown for that index on later visible pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| row_we | input | 1 | Line-store write enable |
| row_waddr | input | AW | Line-store entry to write |
| row_wdata | input | IDX_W | Palette index to store |
| pal_we | input | 1 | Palette write enable |
| pal_waddr | input | IDX_W | Palette entry to write |
| pal_wdata | input | COLOR_W | Color to store |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Display enable (active video) |
| vblank | output | 1 | Vertical blank flag |
| color | output | COLOR_W | Output pixel color |
| swap_pulse | output | 1 | One-clock pulse at each store swap |
| free_buf | output | 1 | Store the renderer may write |

## Verification
The assertions check these rules on every clock: syncs stay idle while de is high, vblank and de never overlap, and vsync falls only inside vblank. The swap pulse lasts one clock, comes only during horizontal blank, and free_buf changes exactly when it fires. The second pixel of every doubled pair repeats the first. The assertions cannot show which color each index produces, which store a line displays, where a write lands, or what the line stores hold after reset. The bench's scenarios show these by comparing colors at chosen raster positions against its own model of the stores and the palette.

// File: rtl/scan_pkg.sv
package scan_pkg;

  // Raster flags that travel alongside the pixel pipeline.
  typedef struct packed {
    logic de;
    logic hs_n;
    logic vs_n;
    logic vb;
  } scan_sync_t;

  localparam scan_sync_t SYNC_IDLE = '{de: 1'b0, hs_n: 1'b1, vs_n: 1'b1, vb: 1'b0};

endpackage

// File: rtl/scan_timing.sv
module scan_timing
  import scan_pkg::*;
#(
  parameter int H_ACTIVE = 640,
  parameter int H_FRONT  = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BACK   = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FRONT  = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BACK   = 33,
  localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK,
  localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK,
  localparam int HW      = $clog2(H_TOTAL),
  localparam int VW      = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] h_pos,
  output scan_sync_t    raw,
  output logic          swap,
  output logic          disp_sel
);

  localparam int HS_BEG = H_ACTIVE + H_FRONT;
  localparam int HS_END = HS_BEG + H_SYNC;
  localparam int VS_BEG = V_ACTIVE + V_FRONT;
  localparam int VS_END = VS_BEG + V_SYNC;

  logic [HW-1:0] h_q, h_d;
  logic [VW-1:0] v_q, v_d;
  logic          sel_q, sel_d;
  logic          line_end;
  logic          v_vis;

  always_comb begin
    line_end = (h_q == HW'(H_TOTAL - 1));
    v_vis    = (v_q < VW'(V_ACTIVE));
    h_d      = line_end ? '0 : h_q + 1'b1;
    v_d      = v_q;
    if (line_end) begin
      v_d = (v_q == VW'(V_TOTAL - 1)) ? '0 : v_q + 1'b1;
    end
    swap  = line_end && v_vis;
    sel_d = sel_q ^ swap;
  end

  always_comb begin
    raw.de   = (h_q < HW'(H_ACTIVE)) && v_vis;
    raw.hs_n = !((h_q >= HW'(HS_BEG)) && (h_q < HW'(HS_END)));
    raw.vs_n = !((v_q >= VW'(VS_BEG)) && (v_q < VW'(VS_END)));
    raw.vb   = !v_vis;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q   <= '0;
      v_q   <= '0;
      sel_q <= 1'b0;
    end else begin
      h_q   <= h_d;
      v_q   <= v_d;
      sel_q <= sel_d;
    end
  end

  assign h_pos    = h_q;
  assign disp_sel = sel_q;

endmodule

// File: rtl/scan_rowbuf.sv
module scan_rowbuf #(
  parameter int SRC_W = 320,
  parameter int IDX_W = 8,
  localparam int AW   = $clog2(SRC_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_sel,
  input  logic [AW-1:0]    rd_addr,
  output logic [IDX_W-1:0] rd_idx,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [IDX_W-1:0] wr_idx
);

  logic [IDX_W-1:0] store [2][SRC_W];
  logic             wr_sel;
  logic             wr_ok;

  always_comb begin
    wr_sel = ~rd_sel;
    wr_ok  = wr_en && (int'(wr_addr) < SRC_W);
    rd_idx = (int'(rd_addr) < SRC_W) ? store[rd_sel][rd_addr] : '0;
  end

  // Reset loads a test pattern: ramp in store 0, inverted ramp in store 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SRC_W; i++) begin
        store[0][i] <= IDX_W'(i);
        store[1][i] <= ~IDX_W'(i);
      end
    end else if (wr_ok) begin
      store[wr_sel][wr_addr] <= wr_idx;
    end
  end

endmodule

// File: rtl/scan_palette.sv
module scan_palette #(
  parameter int IDX_W   = 8,
  parameter int COLOR_W = 24,
  localparam int DEPTH  = 1 << IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [IDX_W-1:0]   waddr,
  input  logic [COLOR_W-1:0] wdata,
  input  logic               re,
  input  logic [IDX_W-1:0]   raddr,
  output logic [COLOR_W-1:0] rdata
);

  logic [COLOR_W-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      ram[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (re) begin
      rdata <= ram[raddr];
    end
  end

endmodule

// File: rtl/scan_pixel_out.sv
module scan_pixel_out
  import scan_pkg::*;
#(
  parameter int H_ACTIVE = 640,
  parameter int H_FRONT  = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BACK   = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FRONT  = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BACK   = 33,
  parameter int IDX_W    = 8,
  parameter int COLOR_W  = 24,
  localparam int SRC_W   = H_ACTIVE / 2,
  localparam int AW      = $clog2(SRC_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               row_we,
  input  logic [AW-1:0]      row_waddr,
  input  logic [IDX_W-1:0]   row_wdata,
  input  logic               pal_we,
  input  logic [IDX_W-1:0]   pal_waddr,
  input  logic [COLOR_W-1:0] pal_wdata,
  output logic               hsync_n,
  output logic               vsync_n,
  output logic               de,
  output logic               vblank,
  output logic [COLOR_W-1:0] color,
  output logic               swap_pulse,
  output logic               free_buf
);

  localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
  localparam int HW      = $clog2(H_TOTAL);

  logic [HW-1:0]      h_pos;
  scan_sync_t         sync0, sync1_q, sync2_q;
  logic               swap0, swap_q;
  logic               disp_sel;
  logic [AW-1:0]      rd_addr;
  logic [IDX_W-1:0]   idx0, idx1_q;
  logic [COLOR_W-1:0] pal_q;

  scan_timing #(
    .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC), .H_BACK(H_BACK),
    .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC), .V_BACK(V_BACK)
  ) u_timing (
    .clk      (clk),
    .rst_n    (rst_n),
    .h_pos    (h_pos),
    .raw      (sync0),
    .swap     (swap0),
    .disp_sel (disp_sel)
  );

  // Each source entry covers two raster positions.
  assign rd_addr = AW'(h_pos >> 1);

  scan_rowbuf #(.SRC_W(SRC_W), .IDX_W(IDX_W)) u_rowbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_sel  (disp_sel),
    .rd_addr (rd_addr),
    .rd_idx  (idx0),
    .wr_en   (row_we),
    .wr_addr (row_waddr),
    .wr_idx  (row_wdata)
  );

  // Stage 1: index fetched from the line store.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= SYNC_IDLE;
      idx1_q  <= '0;
      swap_q  <= 1'b0;
    end else begin
      sync1_q <= sync0;
      swap_q  <= swap0;
      if (sync0.de) begin
        idx1_q <= idx0;
      end
    end
  end

  // Stage 2: palette lookup, flags delayed to match.
  scan_palette #(.IDX_W(IDX_W), .COLOR_W(COLOR_W)) u_palette (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (pal_we),
    .waddr (pal_waddr),
    .wdata (pal_wdata),
    .re    (sync1_q.de),
    .raddr (idx1_q),
    .rdata (pal_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync2_q <= SYNC_IDLE;
    end else begin
      sync2_q <= sync1_q;
    end
  end

  assign de         = sync2_q.de;
  assign hsync_n    = sync2_q.hs_n;
  assign vsync_n    = sync2_q.vs_n;
  assign vblank     = sync2_q.vb;
  assign color      = sync2_q.de ? pal_q : '0;
  assign swap_pulse = swap_q;
  assign free_buf   = ~disp_sel;

endmodule

// File: rtl/scan_pixel_out_chk.sv
module scan_pixel_out_chk #(
  parameter int COLOR_W = 24
) (
  input logic               clk,
  input logic               rst_n,
  input logic               hsync_n,
  input logic               vsync_n,
  input logic               de,
  input logic               vblank,
  input logic [COLOR_W-1:0] color,
  input logic               swap_pulse,
  input logic               free_buf
);

  // Number of visible pixels already output on the current run of de.
  logic [15:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (de) begin
      run_q <= run_q + 1'b1;
    end else begin
      run_q <= '0;
    end
  end

  AST_SYNC_IDLE_IN_VIDEO: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (hsync_n && vsync_n)); // R2

  AST_VBLANK_NO_VIDEO: assert property (@(posedge clk) disable iff (!rst_n)
    vblank |-> !de); // R3

  AST_VSYNC_INSIDE_VBLANK: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_n |-> vblank); // R3

  AST_PIXEL_PAIR_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (de && run_q[0]) |-> (color == $past(color))); // R4

  AST_SWAP_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    swap_pulse |=> !swap_pulse); // R8

  AST_SWAP_IN_HBLANK: assert property (@(posedge clk) disable iff (!rst_n)
    swap_pulse |-> (!de && !vblank)); // R8

  AST_FREE_FLIPS_ON_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    swap_pulse |-> (free_buf != $past(free_buf))); // R8

  AST_FREE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_pulse |-> $stable(free_buf)); // R8

endmodule

bind scan_pixel_out scan_pixel_out_chk #(.COLOR_W(COLOR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hsync_n    (hsync_n),
  .vsync_n    (vsync_n),
  .de         (de),
  .vblank     (vblank),
  .color      (color),
  .swap_pulse (swap_pulse),
  .free_buf   (free_buf)
);

// File: tb/sim_scan_pixel_out.sv
`timescale 1ns/1ps
module sim_scan_pixel_out;

  localparam int HA = 16, HF = 2, HS = 3, HB = 3;
  localparam int VA = 4,  VF = 1, VS = 2, VB = 2;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int FT = HT * VT;
  localparam int IW = 4;
  localparam int CW = 12;
  localparam int SW = HA / 2;
  localparam int AW = $clog2(SW);

  // {h, v, de, hsync_n, vsync_n, vblank}
  localparam logic [19:0] VEC [12] = '{
    {8'd0,  8'd0, 4'b1110},
    {8'd15, 8'd0, 4'b1110},
    {8'd16, 8'd0, 4'b0110},
    {8'd18, 8'd1, 4'b0010},
    {8'd20, 8'd2, 4'b0010},
    {8'd21, 8'd3, 4'b0110},
    {8'd5,  8'd4, 4'b0111},
    {8'd3,  8'd5, 4'b0101},
    {8'd19, 8'd6, 4'b0001},
    {8'd23, 8'd8, 4'b0111},
    {8'd7,  8'd3, 4'b1110},
    {8'd9,  8'd2, 4'b1110}
  };

  logic          clk;
  logic          rst_n;
  logic          row_we;
  logic [AW-1:0] row_waddr;
  logic [IW-1:0] row_wdata;
  logic          pal_we;
  logic [IW-1:0] pal_waddr;
  logic [CW-1:0] pal_wdata;
  logic          hsync_n, vsync_n, de, vblank, swap_pulse, free_buf;
  logic [CW-1:0] color;

  int checks   = 0;
  int failures = 0;
  int n;
  bit done = 0;

  logic [IW-1:0] mb [2][SW];
  logic [CW-1:0] mp [1 << IW];

  scan_pixel_out #(
    .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
    .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB),
    .IDX_W(IW), .COLOR_W(CW)
  ) u0 (
    .clk(clk), .rst_n(rst_n),
    .row_we(row_we), .row_waddr(row_waddr), .row_wdata(row_wdata),
    .pal_we(pal_we), .pal_waddr(pal_waddr), .pal_wdata(pal_wdata),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de), .vblank(vblank),
    .color(color), .swap_pulse(swap_pulse), .free_buf(free_buf)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Clock edges since reset release; after edge n the outputs show raster position n-2.
  always @(posedge clk) begin
    if (!rst_n) n <= 0;
    else        n <= n + 1;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] exp_color(input int h, input int v);
    int sel;
    if (h >= HA || v >= VA) return '0;
    sel = v % 2;
    return mp[mb[sel][h / 2]];
  endfunction

  task automatic goto_n(input int t);
    while (n < t) @(negedge clk);
  endtask

  task automatic row_write(input int a, input logic [IW-1:0] d);
    row_we = 1'b1; row_waddr = AW'(a); row_wdata = d;
    @(negedge clk);
    row_we = 1'b0;
  endtask

  task automatic pal_write(input int a, input logic [CW-1:0] d);
    pal_we = 1'b1; pal_waddr = IW'(a); pal_wdata = d;
    @(negedge clk);
    pal_we = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int base, t, h, v;
    rst_n = 1'b0; row_we = 1'b0; row_waddr = '0; row_wdata = '0;
    pal_we = 1'b0; pal_waddr = '0; pal_wdata = '0;

    for (int i = 0; i < SW; i++) begin
      mb[0][i] = IW'(i);   // R10 ramp
      mb[1][i] = ~IW'(i);  // R10 inverted ramp
    end
    @(negedge clk);
    for (int i = 0; i < (1 << IW); i++) begin
      mp[i] = CW'((i * 12'h111) ^ 12'h5A3);
      pal_write(i, mp[i]);
    end

    // R1: state held in reset
    chk("R1", "de", de, 0);
    chk("R1", "hsync_n", hsync_n, 1);
    chk("R1", "vsync_n", vsync_n, 1);
    chk("R1", "vblank", vblank, 0);
    chk("R1", "color", color, 0);
    chk("R1", "swap_pulse", swap_pulse, 0);
    chk("R1", "free_buf", free_buf, 1);
    rst_n = 1'b1;

    // Vector walk: R2/R3 flags, R5/R6/R10 colors from the reset pattern
    for (int k = 0; k < 12; k++) begin
      h = int'(VEC[k][19:12]);
      v = int'(VEC[k][11:4]);
      t = v * HT + h + 2;
      while (t <= n) t += FT;
      goto_n(t);
      chk("R2", "de", de, VEC[k][3]);
      chk("R2", "hsync_n", hsync_n, VEC[k][2]);
      chk("R3", "vsync_n", vsync_n, VEC[k][1]);
      chk("R3", "vblank", vblank, VEC[k][0]);
      chk(VEC[k][3] ? "R5/R10" : "R6", "color", color, exp_color(h, v));
    end

    // Directed: writes during line 0 (store 0 shown, store 1 free)
    base = (n / FT + 1) * FT;
    goto_n(base + 2);
    row_write(3, 4'hA); mb[1][3] = 4'hA;   // R9
    goto_n(base + 4);
    row_write(5, 4'hC); mb[1][5] = 4'hC;   // R9
    goto_n(base + 10 + 2);
    chk("R9", "shown line kept", color, mp[5]);
    goto_n(base + HT + 6 + 2);
    chk("R9", "written entry shown", color, mp[4'hA]);
    goto_n(base + HT + 7 + 2);
    chk("R4", "second of pair", color, mp[4'hA]);
    goto_n(base + HT + 10 + 2);
    chk("R9", "second write shown", color, mp[4'hC]);
    goto_n(base + HT + HT - 1 + 1);
    chk("R8", "swap at end of visible line", swap_pulse, 1);
    chk("R8", "free_buf after swap", free_buf, 1);
    goto_n(base + 2 * HT + 1);
    chk("R8", "swap lasts one clock", swap_pulse, 0);
    goto_n(base + 4 * HT + HT - 1 + 1);
    chk("R8", "no swap on blank line", swap_pulse, 0);
    goto_n(base + 6 * HT);
    pal_write(5, 12'hFFF); mp[5] = 12'hFFF;   // R11

    base = base + FT;
    goto_n(base + 2);
    chk("R7", "frame starts on store 0", color, mp[mb[0][0]]);
    chk("R7", "de at frame start", de, 1);
    goto_n(base + 10 + 2);
    chk("R11", "new palette color", color, 12'hFFF);
    goto_n(base + 11 + 2);
    chk("R11", "new palette color pair", color, 12'hFFF);
    goto_n(base + 2 * HT + 6 + 2);
    chk("R7", "line 2 on store 0", color, exp_color(6, 2));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule